// File: doc/BRIEF.md
# SuperSpeed Front-End Tuning Sequencer

This block runs a short, fixed tuning script for the SuperSpeed analog front end of a USB PHY. Software or a power-up controller pulses a calibrate request. The block then sends three register writes, one at a time, to a control-register port master. The port master answers each write with a done pulse, and may flag an error with it. The value of the last write is a receiver-detect measurement time. The block picks it from the 3-bit reference-clock code that it captures with the request.

A request can name the SuperSpeed instance instead of the high-speed one. Such a request needs no tuning: the block reports completion at once and issues no writes. If any write fails, the script stops there and the block reports the error with its completion pulse.

Top module: `ssc_tune_seq`

## Requirements
- R1: After reset, `wr_req`, `cal_done` and `cal_err` are all low.
- R2: A request sampled with `cal_is_ss`=1 while idle gives a `cal_done` pulse on the next cycle, with `cal_err`=0 and no write.
- R3: The first write goes to address 0x0015 with data 0xA409: bias 5 in bits [15:13], override enable in bit 10, level 9 in bits [4:0].
- R4: The second write goes to address 0x0012 with data 0xA000: boost level 5 in bits [15:13].
- R5: The third write goes to address 0x1010 with a measurement time in bits [15:4]. The time is 0x20 for code 7 (50 MHz), 0x4 for code 3 (19.2 MHz) or code 4 (20 MHz), and 0x8 for code 5 (24 MHz) or any other code. The code is the one sampled with the request, and later changes on `ref_code` have no effect.
- R6: Each write is a one-cycle `wr_req` pulse, with address and data valid in that cycle. A write after the first is issued in the cycle after the previous write's `wr_done`, and never earlier.
- R7: One cycle after the third write's `wr_done` without error, `cal_done` pulses for exactly one cycle with `cal_err`=0.
- R8: A `wr_done` with `wr_err`=1 ends the script. No further write follows, and one cycle later `cal_done` pulses with `cal_err`=1.
- R9: `cal_req` while a script runs, and `wr_done` while idle, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Calibrate request, sampled while idle |
| cal_is_ss | input | 1 | 1: request is for the SuperSpeed instance (no writes) |
| ref_code | input | 3 | Reference-clock code, captured with the request |
| wr_req | output | 1 | One-cycle write strobe to the port master |
| wr_addr | output | 16 | Write address, valid with `wr_req` |
| wr_data | output | 16 | Write data, valid with `wr_req` |
| wr_done | input | 1 | Port master completion pulse |
| wr_err | input | 1 | Error flag, qualified by `wr_done` |
| cal_done | output | 1 | One-cycle completion pulse |
| cal_err | output | 1 | Error result, valid with `cal_done` |

## Verification
The assertions check the per-cycle handshake on every cycle:
- a strobe never lasts two cycles;
- a good completion that is not the last one is followed at once by the next strobe;
- the last good completion, or a failed one, is followed by the matching result pulse;
- the SuperSpeed shortcut finishes without a write.

Only the bench's scenarios can show the content of the writes. That covers the address and data of each step, the table of measurement times per clock code, and that the code is held from the request. The bench also shows the ignored inputs and the exact write count before an abort. A scoreboard matches every logged write against values computed from the requirements.

// File: rtl/ssc_tune_pkg.sv
package ssc_tune_pkg;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int CODE_W  = 3;
  localparam int N_STEPS = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} tune_st_e;

  localparam logic [CODE_W-1:0] CODE_19M2 = 3'd3;
  localparam logic [CODE_W-1:0] CODE_20M  = 3'd4;
  localparam logic [CODE_W-1:0] CODE_24M  = 3'd5;
  localparam logic [CODE_W-1:0] CODE_50M  = 3'd7;

  localparam logic [15:0] ADDR_LOS   = 16'h0015;
  localparam logic [15:0] ADDR_BOOST = 16'h0012;
  localparam logic [15:0] ADDR_RXDET = 16'h1010;

  // Loss-of-signal override word: bias in [15:13], enable at 10, level in [4:0]
  function automatic logic [15:0] los_word(input logic [2:0] bias,
                                           input logic en,
                                           input logic [4:0] level);
    return {bias, 2'b00, en, 5'b0, level};
  endfunction

  // Transmit boost word: level in [15:13]
  function automatic logic [15:0] boost_word(input logic [2:0] lvl);
    return {lvl, 13'b0};
  endfunction

  // Receiver-detect measurement time, placed from bit 4 upward
  function automatic logic [15:0] rxdet_word(input logic [CODE_W-1:0] code);
    logic [11:0] t;
    case (code)
      CODE_50M:            t = 12'h020;
      CODE_20M, CODE_19M2: t = 12'h004;
      default:             t = 12'h008;
    endcase
    return {t, 4'b0};
  endfunction

endpackage

// File: rtl/ssc_tune_script.sv
module ssc_tune_script
  import ssc_tune_pkg::*;
#(
  parameter int A_W     = ADDR_W,
  parameter int D_W     = DATA_W,
  parameter int C_W     = CODE_W,
  parameter int STEPS   = N_STEPS,
  localparam int STEP_W = $clog2(STEPS)
) (
  input  logic [STEP_W-1:0] step,
  input  logic [C_W-1:0]    code,
  output logic [A_W-1:0]    addr,
  output logic [D_W-1:0]    data
);

  logic [CODE_W-1:0] code_n;
  assign code_n = CODE_W'(code);

  always_comb begin
    case (step)
      STEP_W'(0): begin
        addr = A_W'(ADDR_LOS);
        data = D_W'(los_word(3'd5, 1'b1, 5'd9));
      end
      STEP_W'(1): begin
        addr = A_W'(ADDR_BOOST);
        data = D_W'(boost_word(3'd5));
      end
      default: begin
        addr = A_W'(ADDR_RXDET);
        data = D_W'(rxdet_word(code_n));
      end
    endcase
  end

endmodule

// File: rtl/ssc_tune_ctrl.sv
module ssc_tune_ctrl
  import ssc_tune_pkg::*;
#(
  parameter int C_W     = CODE_W,
  parameter int STEPS   = N_STEPS,
  localparam int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_req,
  input  logic              cal_is_ss,
  input  logic [C_W-1:0]    ref_code,
  input  logic              wr_done,
  input  logic              wr_err,
  output logic              wr_req,
  output logic [STEP_W-1:0] step,
  output logic [C_W-1:0]    code_q,
  output logic              cal_done,
  output logic              cal_err
);

  tune_st_e st;
  logic     done_q, err_q;

  // Named events for the assertions
  logic start_hs, start_ss, step_ok, step_fail, last_step;
  assign start_hs  = (st == ST_IDLE) && cal_req && !cal_is_ss;
  assign start_ss  = (st == ST_IDLE) && cal_req && cal_is_ss;
  assign step_ok   = (st == ST_WAIT) && wr_done && !wr_err;
  assign step_fail = (st == ST_WAIT) && wr_done && wr_err;
  assign last_step = (step == STEP_W'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      step   <= '0;
      code_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_ss) begin
            done_q <= 1'b1;
          end else if (start_hs) begin
            st     <= ST_ISSUE;
            step   <= '0;
            code_q <= ref_code;
          end
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (step_fail) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (step_ok) begin
            if (last_step) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              st   <= ST_ISSUE;
              step <= step + STEP_W'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign wr_req   = (st == ST_ISSUE);
  assign cal_done = done_q;
  assign cal_err  = err_q;

  p_ss_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ss |=> (cal_done && !cal_err && !wr_req));
  p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);
  p_next_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !last_step) |=> (wr_req && !cal_done));
  p_step_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step < STEP_W'(STEPS));
  p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && last_step) |=> (cal_done && !cal_err));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_fail |=> (cal_done && cal_err && !wr_req));
  p_err_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |-> cal_done);
  p_idle_done_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && !cal_req) |=> (!wr_req && !cal_done));

endmodule

// File: rtl/ssc_tune_seq.sv
module ssc_tune_seq
  import ssc_tune_pkg::*;
#(
  parameter int A_W   = ADDR_W,
  parameter int D_W   = DATA_W,
  parameter int C_W   = CODE_W,
  parameter int STEPS = N_STEPS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cal_req,
  input  logic           cal_is_ss,
  input  logic [C_W-1:0] ref_code,
  output logic           wr_req,
  output logic [A_W-1:0] wr_addr,
  output logic [D_W-1:0] wr_data,
  input  logic           wr_done,
  input  logic           wr_err,
  output logic           cal_done,
  output logic           cal_err
);

  localparam int STEP_W = $clog2(STEPS);

  logic [STEP_W-1:0] step;
  logic [C_W-1:0]    code_q;

  ssc_tune_ctrl #(.C_W(C_W), .STEPS(STEPS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_req   (cal_req),
    .cal_is_ss (cal_is_ss),
    .ref_code  (ref_code),
    .wr_done   (wr_done),
    .wr_err    (wr_err),
    .wr_req    (wr_req),
    .step      (step),
    .code_q    (code_q),
    .cal_done  (cal_done),
    .cal_err   (cal_err)
  );

  ssc_tune_script #(.A_W(A_W), .D_W(D_W), .C_W(C_W), .STEPS(STEPS)) u_script (
    .step (step),
    .code (code_q),
    .addr (wr_addr),
    .data (wr_data)
  );

endmodule

// File: tb/ssc_tune_seq_test.sv
module ssc_tune_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_req = 1'b0, cal_is_ss = 1'b0;
  logic [2:0]  ref_code = 3'd0;
  logic        wr_req, wr_done = 1'b0, wr_err = 1'b0;
  logic [15:0] wr_addr, wr_data;
  logic        cal_done, cal_err;

  int checks = 0, failures = 0;
  int tick = 0, done_tick = -10;
  int wcount = 0, model_lat = 1, model_fail_at = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  ssc_tune_seq uut (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cal_is_ss(cal_is_ss),
    .ref_code(ref_code), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .wr_err(wr_err), .cal_done(cal_done), .cal_err(cal_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_time(input logic [2:0] c);
    if (c == 3'd7) return 16'h0200;
    if (c == 3'd3 || c == 3'd4) return 16'h0040;
    return 16'h0080;
  endfunction

  // Model port master and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      wr_done = 1'b0;
      wr_err  = 1'b0;
      if (wr_req) begin
        if (wcount > 0)
          chk(tick == done_tick + 1, "R6 strobe timing", tick, done_tick + 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected write", {wr_addr, wr_data}, 0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk({wr_addr, wr_data} == e, "R3/R4/R5 write content",
              {wr_addr, wr_data}, e);
        end
        wcount++;
        @(negedge clk);
        chk(wr_req == 1'b0, "R6 strobe width", wr_req, 0);
        repeat (model_lat - 1) @(negedge clk);
        wr_done   = 1'b1;
        wr_err    = (wcount == model_fail_at);
        done_tick = tick;
      end
    end
  end

  task automatic run_cal(input bit is_ss, input logic [2:0] code, input int lat,
                         input int fail_at, input bit poke_busy);
    int n;
    int t0;
    bit seen;
    model_lat = lat;
    model_fail_at = fail_at;
    wcount = 0;
    n = is_ss ? 0 : (fail_at != 0 ? fail_at : 3);
    if (n >= 1) exp_q.push_back({16'h0015, 16'hA409});
    if (n >= 2) exp_q.push_back({16'h0012, 16'hA000});
    if (n >= 3) exp_q.push_back({16'h1010, exp_time(code)});
    @(negedge clk);
    cal_req = 1'b1; cal_is_ss = is_ss; ref_code = code;
    t0 = tick;
    @(negedge clk);
    cal_req = 1'b0;
    ref_code = (code == 3'd7) ? 3'd3 : 3'd7;  // later change must not matter (R5)
    if (is_ss) begin
      chk(cal_done == 1'b1, "R2 immediate done", cal_done, 1);
      chk(cal_err == 1'b0, "R2 no error", cal_err, 0);
      seen = 1;
    end else begin
      seen = 0;
      if (poke_busy) begin
        @(negedge clk);
        cal_req = 1'b1; cal_is_ss = 1'b1;
        @(negedge clk);
        cal_req = 1'b0; cal_is_ss = 1'b0;
        chk(cal_done == 1'b0, "R9 busy request ignored", cal_done, 0);
      end
      for (int i = 0; i < 200 && !seen; i++) begin
        if (cal_done) seen = 1;
        else @(negedge clk);
      end
      chk(seen, "R7 completion seen", seen, 1);
      chk(tick == done_tick + 1, "R7/R8 done timing", tick, done_tick + 1);
      chk(cal_err == (fail_at != 0), "R7/R8 error flag", cal_err, fail_at != 0);
    end
    @(negedge clk);
    chk(cal_done == 1'b0, "R7 done is one pulse", cal_done, 0);
    repeat (4) @(negedge clk);
    chk(wcount == n, "R2/R8 write count", wcount, n);
    chk(exp_q.size() == 0, "R6 all expected writes issued", exp_q.size(), 0);
    if (t0 < 0) $display("unreachable");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_req == 0 && cal_done == 0 && cal_err == 0, "R1 reset state",
        {wr_req, cal_done, cal_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_cal(1'b1, 3'd5, 1, 0, 1'b0);  // R2
    run_cal(1'b0, 3'd5, 1, 0, 1'b0);  // R3 R4 R5 R7, 24 MHz
    run_cal(1'b0, 3'd7, 2, 0, 1'b0);  // R5 50 MHz
    run_cal(1'b0, 3'd3, 3, 0, 1'b0);  // R5 19.2 MHz
    run_cal(1'b0, 3'd4, 1, 0, 1'b0);  // R5 20 MHz
    run_cal(1'b0, 3'd0, 2, 0, 1'b0);  // R5 other code
    run_cal(1'b0, 3'd5, 2, 2, 1'b0);  // R8 fail on second write
    run_cal(1'b0, 3'd7, 1, 1, 1'b0);  // R8 fail on first write
    run_cal(1'b0, 3'd3, 1, 3, 1'b0);  // R8 fail on third write
    run_cal(1'b0, 3'd5, 4, 0, 1'b1);  // R9 request while busy
    // R9: completion pulse while idle
    @(negedge clk);
    wr_done = 1'b1; wr_err = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cal_done == 0 && wr_req == 0, "R9 idle done ignored",
          {cal_done, wr_req}, 0);
    end
    run_cal(1'b0, 3'd4, 1, 0, 1'b0);  // still works after spurious done
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule